// File: doc/BRIEF.md
# Infix to Postfix Token Converter

This block takes an arithmetic expression one token at a time in infix form and writes the same expression out in postfix order. The input tokens are signed operands, the binary operators add, subtract, bitwise AND and bitwise OR, and opening and closing brackets. An operator stack holds operators and open brackets until their place in the postfix stream is known. Every postfix token leaves as a fixed 18-bit tagged word on a valid/ready stream, which feeds the queue of a separate evaluator.

All four operators share one precedence level and group from the left. The last token of an expression carries an end marker. After it is taken, the block empties its stack into the output and raises `done` for one cycle. Bracket mismatches and stack overflow set an error flag. The flag stays set until reset.

Back-pressure: on each port a token moves only in a cycle where valid and ready are both high. `out_valid` and `out_data` hold steady while `out_ready` is low. `in_ready` is high only when the block is waiting for a new token and its single output slot is free or is being drained in that cycle. So at most one token enters and at most one token leaves per cycle.

Top module: `infix_postfix_conv`

## Requirements
- R1: Output token format. Bit 17 is 1 for an operator and 0 for an operand. An operand carries the input value in bits 16:0 unchanged, and bit 16 is its sign. An operator carries its 5-bit code in bits 4:0, and bits 16:5 are zero. The bench uses the codes add=1, subtract=2, AND=3 and OR=4. On the input, `in_kind` is 0 for an operand, 1 for an operator, 2 for an opening bracket and 3 for a closing bracket. `in_data` holds either the operand value or, in bits 4:0, the operator code.
- R2: Operands are emitted in their input order, as soon as they are accepted.
- R3: All operators have equal precedence and are left-associative. An incoming operator first causes every stacked operator above the nearest opening bracket (or down to the bottom of the stack) to be emitted, and is then pushed.
- R4: An opening bracket is pushed. A closing bracket emits the stacked operators down to the matching opening bracket and then discards that bracket. Brackets never appear in the output, and nesting to any depth the stack allows is supported.
- R5: After the end-marked token, the remaining stacked operators are emitted from top to bottom. `done` then goes high for exactly one cycle, after the last postfix token has been presented.
- R6: A closing bracket with no matching opening bracket sets `error`.
- R7: An opening bracket still on the stack at end of expression sets `error`, and the bracket is discarded without being emitted.
- R8: The stack holds 16 entries. A push onto a full stack is dropped and sets `error`.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged and `in_ready` is low.
- R10: `in_ready` is low while operators are being popped for an incoming operator or closing bracket, and low during the end-of-expression flush.
- R11: After reset, `in_ready` is 1 and `out_valid`, `done` and `error` are 0. `error` stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Block can take an input token |
| in_kind | input | 2 | Token kind: 0 operand, 1 operator, 2 open bracket, 3 close bracket |
| in_data | input | 17 | Operand value, or operator code in bits 4:0 |
| in_last | input | 1 | Token is the last one of the expression |
| out_valid | output | 1 | Postfix token valid |
| out_ready | input | 1 | Queue can accept a token (low when full) |
| out_data | output | 18 | Tagged postfix token |
| done | output | 1 | One-cycle pulse when conversion of an expression ends |
| error | output | 1 | Sticky mismatch or overflow flag |

## Verification
The assertions check on every cycle the properties that hold at all times:
- a stalled output token does not change, and no new token is loaded over it;
- the stack is never popped when empty, and a push and a pop never happen in the same cycle;
- no bracket entry is ever sent to the output, and every operator word has clean upper bits;
- `done` lasts a single cycle, `error` stays set once raised, and any push onto a full stack raises `error`.

Only the bench scenarios can show that the postfix order is correct. It runs flat, left-grouped and nested bracket expressions, checks the error outcome of unmatched brackets at either end and of stack overflow, and confirms that `in_ready` drops during the pop and flush phases.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int VALW = 17;
  localparam int OPW  = 5;
  localparam int TOKW = VALW + 1;

  typedef enum logic [1:0] {
    K_OPND  = 2'd0,
    K_OPER  = 2'd1,
    K_OPEN  = 2'd2,
    K_CLOSE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_ACCEPT = 2'd0,
    S_POPOP  = 2'd1,
    S_POPCL  = 2'd2,
    S_FLUSH  = 2'd3
  } state_e;

  typedef struct packed {
    logic           is_open;
    logic [OPW-1:0] op;
  } sentry_t;
endpackage

// File: rtl/ipc_op_stack.sv
module ipc_op_stack
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  logic    pop,
  input  sentry_t wdata,
  output sentry_t top,
  output logic    empty,
  output logic    full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  sentry_t        mem [DEPTH];
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  cnt_m1;

  assign empty  = (cnt == '0);
  assign full   = (cnt == FULLC);
  assign cnt_m1 = cnt - 1'b1;
  assign top    = empty ? '0 : mem[AW'(cnt_m1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[AW'(cnt)] <= wdata;
      cnt           <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt_m1;
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

  // R8
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/ipc_out_slot.sv
module ipc_out_slot
  import ipc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TOKW-1:0] ldata,
  output logic            can_load,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TOKW-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ldata;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);

  // R1
  oper_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[TOKW-1]) |-> (out_data[VALW-1:OPW] == '0));
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_kind,
  input  logic [VALW-1:0] in_data,
  input  logic            in_last,
  input  logic            can_emit,
  input  sentry_t         stk_top,
  input  logic            stk_empty,
  input  logic            stk_full,
  output logic            push,
  output sentry_t         push_data,
  output logic            pop,
  output logic            load,
  output logic [TOKW-1:0] ldata,
  output logic            done,
  output logic            error
);
  state_e         state, nxt;
  logic [OPW-1:0] pend_op, pend_op_n;
  logic           pend_last, pend_last_n;
  logic           set_err, set_done, emit_stack;
  kind_e          kind;
  logic           top_is_op;

  assign kind      = kind_e'(in_kind);
  assign top_is_op = !stk_empty && !stk_top.is_open;

  always_comb begin
    nxt         = state;
    pend_op_n   = pend_op;
    pend_last_n = pend_last;
    in_ready    = 1'b0;
    push        = 1'b0;
    push_data   = '0;
    pop         = 1'b0;
    load        = 1'b0;
    ldata       = '0;
    set_err     = 1'b0;
    set_done    = 1'b0;
    emit_stack  = 1'b0;
    unique case (state)
      S_ACCEPT: begin
        in_ready = can_emit;
        if (in_valid && can_emit) begin
          unique case (kind)
            K_OPND: begin
              load  = 1'b1;
              ldata = {1'b0, in_data};
              nxt   = in_last ? S_FLUSH : S_ACCEPT;
            end
            K_OPEN: begin
              push      = 1'b1;
              push_data = '{is_open: 1'b1, op: '0};
              set_err   = stk_full;
              nxt       = in_last ? S_FLUSH : S_ACCEPT;
            end
            K_OPER: begin
              if (top_is_op) begin
                pend_op_n   = in_data[OPW-1:0];
                pend_last_n = in_last;
                nxt         = S_POPOP;
              end else begin
                push      = 1'b1;
                push_data = '{is_open: 1'b0, op: in_data[OPW-1:0]};
                set_err   = stk_full;
                nxt       = in_last ? S_FLUSH : S_ACCEPT;
              end
            end
            K_CLOSE: begin
              pend_last_n = in_last;
              nxt         = S_POPCL;
            end
            default: ;
          endcase
        end
      end
      S_POPOP: begin
        if (!top_is_op) begin
          push      = 1'b1;
          push_data = '{is_open: 1'b0, op: pend_op};
          set_err   = stk_full;
          nxt       = pend_last ? S_FLUSH : S_ACCEPT;
        end else if (can_emit) begin
          emit_stack = 1'b1;
        end
      end
      S_POPCL: begin
        if (stk_empty) begin
          set_err = 1'b1;
          nxt     = pend_last ? S_FLUSH : S_ACCEPT;
        end else if (stk_top.is_open) begin
          pop = 1'b1;
          nxt = pend_last ? S_FLUSH : S_ACCEPT;
        end else if (can_emit) begin
          emit_stack = 1'b1;
        end
      end
      S_FLUSH: begin
        if (stk_empty) begin
          set_done = 1'b1;
          nxt      = S_ACCEPT;
        end else if (stk_top.is_open) begin
          pop     = 1'b1;
          set_err = 1'b1;
        end else if (can_emit) begin
          emit_stack = 1'b1;
        end
      end
      default: nxt = S_ACCEPT;
    endcase
    if (emit_stack) begin
      pop   = 1'b1;
      load  = 1'b1;
      ldata = {1'b1, {(VALW-OPW){1'b0}}, stk_top.op};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_ACCEPT;
      pend_op   <= '0;
      pend_last <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state     <= nxt;
      pend_op   <= pend_op_n;
      pend_last <= pend_last_n;
      done      <= set_done;
      if (set_err) error <= 1'b1;
    end
  end

  // R4
  no_bracket_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && load) |-> !stk_top.is_open);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R10
  one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: rtl/infix_postfix_conv.sv
module infix_postfix_conv
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_kind,
  input  logic [VALW-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TOKW-1:0] out_data,
  output logic            done,
  output logic            error
);
  sentry_t         stk_top, push_data;
  logic            stk_empty, stk_full, push, pop;
  logic            load, can_emit;
  logic [TOKW-1:0] ldata;

  ipc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_data   (in_data),
    .in_last   (in_last),
    .can_emit  (can_emit),
    .stk_top   (stk_top),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .load      (load),
    .ldata     (ldata),
    .done      (done),
    .error     (error)
  );

  ipc_op_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (push_data),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  ipc_out_slot u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ldata     (ldata),
    .can_load  (can_emit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && stk_full) |=> error);
endmodule

// File: tb/infix_postfix_conv_tb.sv
module infix_postfix_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic [16:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_data;
  logic        done;
  logic        error;

  int tests = 0;
  int fails = 0;
  string got = "";
  logic [17:0] raw [64];
  int nraw = 0;

  always #5 clk = ~clk;

  infix_postfix_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .error(error)
  );

  localparam int NV = 8;
  localparam logic [95:0] EXPR [NV] = '{
    "1+2", "1+2-3", "1-(2&3)", "(1|2)&(3+4)",
    "1+((2-3)|4)", "5", "1+2)", "(1+2"};
  localparam logic [95:0] EXPS [NV] = '{
    "12+", "12+3-", "123&-", "12|34+&",
    "123-4|+", "5", "12+", "12+"};
  localparam bit EXPE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};

  function automatic byte tok2chr(logic [17:0] t);
    if (!t[17]) return byte'(8'd48 + t[7:0]);
    case (t[4:0])
      5'd1: return "+";
      5'd2: return "-";
      5'd3: return "&";
      5'd4: return "|";
      default: return "?";
    endcase
  endfunction

  function automatic string p2s(logic [95:0] v);
    string s = "";
    for (int i = 11; i >= 0; i--)
      if (v[i*8 +: 8] != 8'd0) s = $sformatf("%s%c", s, v[i*8 +: 8]);
    return s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got = $sformatf("%s%c", got, tok2chr(out_data));
      if (nraw < 64) raw[nraw] = out_data;
      nraw++;
    end
  end

  task automatic chk(bit ok, string req, string what, string act, string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    got = ""; nraw = 0;
    #1;
  endtask

  task automatic send(logic [1:0] k, logic [16:0] d, logic l);
    in_valid = 1'b1; in_kind = k; in_data = d; in_last = l;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_chr(byte c, logic l);
    case (c)
      "+": send(2'd1, 17'd1, l);
      "-": send(2'd1, 17'd2, l);
      "&": send(2'd1, 17'd3, l);
      "|": send(2'd1, 17'd4, l);
      "(": send(2'd2, 17'd0, l);
      ")": send(2'd3, 17'd0, l);
      default: send(2'd0, 17'(c - 8'd48), l);
    endcase
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      #1;
      if (done) seen = 1'b1; else @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    // R11 reset state
    do_reset();
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0 && error == 1'b0,
        "R11", "reset state", $sformatf("%b%b%b%b", in_ready, out_valid, done, error), "1000");

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int i = 11; i >= 0; i--)
        if (EXPR[v][i*8 +: 8] != 8'd0) send_chr(EXPR[v][i*8 +: 8], i == 0);
      wait_done(seen);
      chk(seen && got == p2s(EXPS[v]), "R2/R3/R4/R5", p2s(EXPR[v]), got, p2s(EXPS[v]));
      chk(error == EXPE[v], EXPE[v] ? "R6/R7" : "R4", $sformatf("error for %s", p2s(EXPR[v])),
          $sformatf("%b", error), $sformatf("%b", EXPE[v]));
      @(negedge clk); #1;
      chk(done == 1'b0, "R5", "done single cycle", $sformatf("%b", done), "0");
    end

    // R1 negative operand passes through unchanged
    do_reset();
    send(2'd0, 17'h1_0005, 1'b1);
    wait_done(seen);
    chk(nraw == 1 && raw[0] == 18'h1_0005, "R1", "negative operand word",
        $sformatf("%h", raw[0]), "10005");

    // R1 operator word format
    do_reset();
    send(2'd0, 17'd1, 1'b0); send(2'd1, 17'd3, 1'b0); send(2'd0, 17'd2, 1'b1);
    wait_done(seen);
    chk(nraw == 3 && raw[2] == 18'h2_0003, "R1", "operator word",
        $sformatf("%h", raw[2]), "20003");

    // R9 back-pressure
    do_reset();
    out_ready = 1'b0;
    send(2'd0, 17'd3, 1'b0);
    in_valid = 1'b1; in_kind = 2'd1; in_data = 17'd1; in_last = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(in_ready == 1'b0 && out_valid && out_data == 18'd3, "R9", "stall hold",
          $sformatf("%b%b %h", in_ready, out_valid, out_data), "01 00003");
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    send(2'd1, 17'd1, 1'b0);
    send(2'd0, 17'd4, 1'b1);
    wait_done(seen);
    chk(seen && got == "34+", "R9", "result after stall", got, "34+");

    // R10 ready low while popping and flushing
    do_reset();
    send_chr("1", 0); send_chr("+", 0); send_chr("2", 0); send_chr("-", 0);
    #1;
    chk(in_ready == 1'b0, "R10", "ready during operator pop", $sformatf("%b", in_ready), "0");
    send_chr("3", 1);
    #1;
    chk(in_ready == 1'b0, "R10", "ready during flush", $sformatf("%b", in_ready), "0");
    wait_done(seen);
    chk(seen && got == "12+3-", "R10", "result", got, "12+3-");

    // R8 stack overflow
    do_reset();
    for (int i = 0; i < 16; i++) send(2'd2, 17'd0, 1'b0);
    #1;
    chk(error == 1'b0, "R8", "16 opens fit", $sformatf("%b", error), "0");
    send(2'd2, 17'd0, 1'b0);
    #1;
    chk(error == 1'b1, "R8", "17th open overflows", $sformatf("%b", error), "1");
    send(2'd0, 17'd7, 1'b1);
    wait_done(seen);
    chk(seen && got == "7" && error, "R8", "drain after overflow", got, "7");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule